// File: doc/BRIEF.md
# PWM Prescale and Modulo Calculator

This block converts a PWM request into the settings that a timer with one shared counter needs. The request is a period and a duty, both counted in input-clock cycles, plus an enable bit. The block returns four values: a prescale exponent, a modulo value for the counter, the compare value for the channel, and the period the timer will actually produce. The counter can hold at most 16 bits, so long periods are divided down by a power of two. The smallest exponent that lets the period fit is chosen, and every division rounds to the nearest result rather than truncating.

A one-cycle `start` pulse launches an operation and captures the request. `busy` then stays high until the one-cycle `done` pulse. The result and its error flags are valid in the `done` cycle and stay unchanged until the next `done`.

Two requests are rejected early, in the first cycle of the operation, and no arithmetic is performed for them:
- A period that would need an exponent above the 3-bit range raises the range error.
- A period that rounds to zero counts raises the invalid error.

The compare value comes from a multiply followed by a restoring divider that produces one quotient bit per clock.

Top module: `pwm_prescale_calc`

## Requirements
- R1: For a period of 0xFFFF cycles or less, the prescale is 0. Above that, the prescale is the bit index of the highest set bit of the period, plus one, minus 16.
- R2: When the prescale from R1 would exceed 7, the result has `err_range`=1 and `err_invalid`=0. Prescale, modulo, achieved and compare are then all 0.
- R3: The count is (period + (2^prescale >> 1)) >> prescale, which rounds to the nearest count. The modulo output is this count minus one. For example, a period of 0x1FFFF gives a modulo of 0xFFFF.
- R4: A count of zero, which happens only for a period of 0, gives `err_invalid`=1 and `err_range`=0. All value outputs are then 0.
- R5: The achieved period is the count shifted left by the prescale.
- R6: When the enable bit was 0 at start, the duty is treated as 0, so compare is 0 whatever duty was given.
- R7: The compare value is (modulo × duty + (achieved >> 1)) / achieved, using integer division.
- R8: `busy` rises in the cycle after the edge that samples `start`. `done` is high for exactly one cycle, and `busy` is high during it.
- R9: For an accepted request, `done` comes 52 clock edges after the edge that sampled `start`. For a request rejected under R2 or R4, it comes 1 edge after.
- R10: A `start` pulse while `busy` is high is ignored. The running operation keeps its timing and its result, and its request values are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle launch pulse, sampled only when idle |
| req_period | input | 32 | Requested period in input-clock cycles |
| req_duty | input | 32 | Requested active time in input-clock cycles |
| req_enable | input | 1 | Request enabled; 0 forces a zero duty |
| busy | output | 1 | Operation in progress, through the done cycle |
| done | output | 1 | One-cycle result-valid pulse |
| prescale | output | 3 | Counter clock divider exponent |
| modulo | output | 16 | Counter terminal value (count minus one) |
| achieved | output | 24 | Period actually produced, in input-clock cycles |
| compare | output | 32 | Channel compare value |
| err_range | output | 1 | Period too long for any prescale |
| err_invalid | output | 1 | Period rounds to zero counts |

## Verification
The bench builds the block with its default widths: a 32-bit period and duty, a 16-bit counter and a 3-bit prescale. With these widths, every boundary can be reached with ordinary stimulus:
- the prescale steps at 0xFFFF/0x10000;
- rounding up to a full 0x10000 count;
- the range error at 2^23;
- the zero-period rejection;
- duty values above the period.

A behavioural model computes each expected result with 64-bit integer arithmetic. It tracks the expected `busy` and `done` levels cycle by cycle, and these are compared on every clock. Randomized periods with random shift amounts exercise every prescale value and the range error.

// File: rtl/pwmc_pkg.sv
package pwmc_pkg;

    // Controller phases of one conversion
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREP,
        ST_MUL,
        ST_DIV,
        ST_FIN
    } phase_t;

    // Rejection flags produced by the scaling stage
    typedef struct packed {
        logic too_long;
        logic zero_cnt;
    } reject_t;

    // Default geometry of the timer the settings are computed for
    localparam int DEF_CNT_W  = 32;
    localparam int DEF_DUTY_W = 32;
    localparam int DEF_MOD_W  = 16;
    localparam int DEF_PS_W   = 3;

    function automatic int ach_width(input int mod_w, input int ps_w);
        return mod_w + 1 + ((1 << ps_w) - 1);
    endfunction

endpackage

// File: rtl/pwmc_lead_one.sv
module pwmc_lead_one #(
    parameter int W = 32,
    localparam int IDX_W = $clog2(W)
) (
    input  logic [W-1:0]     vec,
    output logic [IDX_W-1:0] idx,
    output logic             any
);
    // Lowest to highest scan: the last set bit seen wins
    always_comb begin
        idx = '0;
        any = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (vec[i]) begin
                idx = IDX_W'(i);
                any = 1'b1;
            end
        end
    end
endmodule

// File: rtl/pwmc_scaler.sv
module pwmc_scaler
    import pwmc_pkg::*;
#(
    parameter int CNT_W = DEF_CNT_W,
    parameter int MOD_W = DEF_MOD_W,
    parameter int PS_W  = DEF_PS_W,
    localparam int ACH_W = ach_width(MOD_W, PS_W),
    localparam int IDX_W = $clog2(CNT_W),
    localparam int PS_MAX = (1 << PS_W) - 1
) (
    input  logic [CNT_W-1:0] cycles,
    output logic [PS_W-1:0]  ps,
    output logic [MOD_W-1:0] mod_val,
    output logic [ACH_W-1:0] ach,
    output reject_t          rej
);
    logic [IDX_W-1:0] top_idx;
    logic             top_any;
    logic             fits;
    logic [IDX_W:0]   ps_full;
    logic [CNT_W:0]   unit;
    logic [CNT_W:0]   half;
    logic [CNT_W:0]   biased;
    logic [CNT_W:0]   count;

    pwmc_lead_one #(.W(CNT_W)) u_lead (
        .vec (cycles),
        .idx (top_idx),
        .any (top_any)
    );

    generate
        if (CNT_W > MOD_W) begin : g_wide
            assign fits = (cycles[CNT_W-1:MOD_W] == '0);
        end else begin : g_narrow
            assign fits = 1'b1;
        end
    endgenerate

    always_comb begin
        if (fits || !top_any) begin
            ps_full = '0;
        end else begin
            ps_full = (IDX_W+1)'(top_idx) + (IDX_W+1)'(1) - (IDX_W+1)'(MOD_W);
        end
        rej.too_long = (ps_full > (IDX_W+1)'(PS_MAX));
        ps       = ps_full[PS_W-1:0];
        unit     = (CNT_W+1)'(1) << ps;
        half     = unit >> 1;
        biased   = {1'b0, cycles} + half;
        count    = biased >> ps;
        rej.zero_cnt = !rej.too_long && (count == '0);
        mod_val  = MOD_W'(count - (CNT_W+1)'(1));
        ach      = count[ACH_W-1:0] << ps;
    end
endmodule

// File: rtl/pwmc_divider.sv
module pwmc_divider #(
    parameter int NUM_W = 49,
    parameter int DEN_W = 24,
    localparam int CNT_W = $clog2(NUM_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic [NUM_W-1:0] quot,
    output logic             fin
);
    logic             run_q;
    logic [CNT_W-1:0] left_q;
    logic [NUM_W-1:0] num_q;
    logic [DEN_W-1:0] den_q;
    logic [DEN_W-1:0] rem_q;
    logic [DEN_W:0]   trial;
    logic [DEN_W:0]   diff;
    logic             take;

    // One restoring step: bring down a numerator bit and subtract if possible
    always_comb begin
        trial = {rem_q, num_q[NUM_W-1]};
        diff  = trial - {1'b0, den_q};
        take  = (trial >= {1'b0, den_q});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= 1'b0;
            left_q <= '0;
            num_q  <= '0;
            den_q  <= '0;
            rem_q  <= '0;
            quot   <= '0;
            fin    <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (load) begin
                run_q  <= 1'b1;
                left_q <= CNT_W'(NUM_W - 1);
                num_q  <= num;
                den_q  <= den;
                rem_q  <= '0;
                quot   <= '0;
            end else if (run_q) begin
                num_q <= num_q << 1;
                rem_q <= take ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
                quot  <= {quot[NUM_W-2:0], take};
                if (left_q == '0) begin
                    run_q <= 1'b0;
                    fin   <= 1'b1;
                end else begin
                    left_q <= left_q - CNT_W'(1);
                end
            end
        end
    end

    // R7: partial remainder always stays below the divisor
    a_r7_rem_below_den: assert property (@(posedge clk) disable iff (rst)
        run_q |-> (rem_q < den_q));
    // R7: divider signals completion only once per run
    a_r7_fin_single: assert property (@(posedge clk) disable iff (rst)
        fin |-> !run_q);
endmodule

// File: rtl/pwm_prescale_calc.sv
module pwm_prescale_calc
    import pwmc_pkg::*;
#(
    parameter int CNT_W  = DEF_CNT_W,
    parameter int DUTY_W = DEF_DUTY_W,
    parameter int MOD_W  = DEF_MOD_W,
    parameter int PS_W   = DEF_PS_W,
    localparam int ACH_W = ach_width(MOD_W, PS_W),
    localparam int NUM_W = MOD_W + DUTY_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CNT_W-1:0]  req_period,
    input  logic [DUTY_W-1:0] req_duty,
    input  logic              req_enable,
    output logic              busy,
    output logic              done,
    output logic [PS_W-1:0]   prescale,
    output logic [MOD_W-1:0]  modulo,
    output logic [ACH_W-1:0]  achieved,
    output logic [DUTY_W-1:0] compare,
    output logic              err_range,
    output logic              err_invalid
);
    phase_t            phase_q;
    logic [CNT_W-1:0]  per_q;
    logic [DUTY_W-1:0] duty_q;
    logic              en_q;

    logic [PS_W-1:0]   sc_ps;
    logic [MOD_W-1:0]  sc_mod;
    logic [ACH_W-1:0]  sc_ach;
    reject_t           sc_rej;

    logic [PS_W-1:0]   ps_q;
    logic [MOD_W-1:0]  mod_q;
    logic [ACH_W-1:0]  ach_q;

    logic              div_load;
    logic [NUM_W-1:0]  div_num;
    logic [NUM_W-1:0]  div_quot;
    logic              div_fin;
    logic [DUTY_W-1:0] duty_eff;

    pwmc_scaler #(.CNT_W(CNT_W), .MOD_W(MOD_W), .PS_W(PS_W)) u_scale (
        .cycles  (per_q),
        .ps      (sc_ps),
        .mod_val (sc_mod),
        .ach     (sc_ach),
        .rej     (sc_rej)
    );

    // Disabled requests compute with a zero duty
    assign duty_eff = en_q ? duty_q : '0;
    assign div_load = (phase_q == ST_MUL);
    assign div_num  = NUM_W'(mod_q) * NUM_W'(duty_eff) + NUM_W'(ach_q >> 1);

    pwmc_divider #(.NUM_W(NUM_W), .DEN_W(ACH_W)) u_div (
        .clk  (clk),
        .rst  (rst),
        .load (div_load),
        .num  (div_num),
        .den  (ach_q),
        .quot (div_quot),
        .fin  (div_fin)
    );

    assign busy = (phase_q != ST_IDLE);
    assign done = (phase_q == ST_FIN);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q     <= ST_IDLE;
            per_q       <= '0;
            duty_q      <= '0;
            en_q        <= 1'b0;
            ps_q        <= '0;
            mod_q       <= '0;
            ach_q       <= '0;
            prescale    <= '0;
            modulo      <= '0;
            achieved    <= '0;
            compare     <= '0;
            err_range   <= 1'b0;
            err_invalid <= 1'b0;
        end else begin
            unique case (phase_q)
                ST_IDLE: begin
                    if (start) begin
                        per_q   <= req_period;
                        duty_q  <= req_duty;
                        en_q    <= req_enable;
                        phase_q <= ST_PREP;
                    end
                end
                ST_PREP: begin
                    ps_q  <= sc_ps;
                    mod_q <= sc_mod;
                    ach_q <= sc_ach;
                    if (sc_rej.too_long || sc_rej.zero_cnt) begin
                        prescale    <= '0;
                        modulo      <= '0;
                        achieved    <= '0;
                        compare     <= '0;
                        err_range   <= sc_rej.too_long;
                        err_invalid <= sc_rej.zero_cnt;
                        phase_q     <= ST_FIN;
                    end else begin
                        phase_q <= ST_MUL;
                    end
                end
                ST_MUL: begin
                    phase_q <= ST_DIV;
                end
                ST_DIV: begin
                    if (div_fin) begin
                        prescale    <= ps_q;
                        modulo      <= mod_q;
                        achieved    <= ach_q;
                        compare     <= div_quot[DUTY_W-1:0];
                        err_range   <= 1'b0;
                        err_invalid <= 1'b0;
                        phase_q     <= ST_FIN;
                    end
                end
                ST_FIN: begin
                    phase_q <= ST_IDLE;
                end
                default: phase_q <= ST_IDLE;
            endcase
        end
    end

    // R8: done lasts one cycle and sits inside busy
    a_r8_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r8_done_in_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);
    // R10: an operation, once running, runs until done
    a_r10_busy_holds: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy);
    // R10: request values stay frozen while busy
    a_r10_req_frozen: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> $stable(per_q) && $stable(duty_q) && $stable(en_q));
    // R2 / R4: at most one rejection reason at a time
    a_r2_err_exclusive: assert property (@(posedge clk) disable iff (rst)
        done |-> !(err_range && err_invalid));
    // R5: achieved period equals (modulo + 1) scaled by the prescale
    a_r5_achieved_rel: assert property (@(posedge clk) disable iff (rst)
        (done && !err_range && !err_invalid) |->
            (achieved == ((ACH_W'(modulo) + ACH_W'(1)) << prescale)));
    // R6: a disabled request yields a zero compare
    a_r6_disabled_zero: assert property (@(posedge clk) disable iff (rst)
        (done && !en_q) |-> (compare == '0));
    // R7: rounded compare never exceeds the effective duty
    a_r7_cmp_bound: assert property (@(posedge clk) disable iff (rst)
        (done && !err_range && !err_invalid) |-> (compare <= duty_eff));
endmodule

// File: tb/tb_pwm_prescale_calc.sv
module tb_pwm_prescale_calc;
    localparam time CLK_PERIOD = 10ns;
    localparam int  NUM_W      = 16 + 32 + 1;
    localparam int  LAT_OK     = NUM_W + 3;
    localparam int  LAT_ERR    = 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] req_period = '0;
    logic [31:0] req_duty = '0;
    logic        req_enable = 1'b0;
    logic        busy, done;
    logic [2:0]  prescale;
    logic [15:0] modulo;
    logic [23:0] achieved;
    logic [31:0] compare;
    logic        err_range, err_invalid;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_prescale_calc dut (
        .clk(clk), .rst(rst), .start(start),
        .req_period(req_period), .req_duty(req_duty), .req_enable(req_enable),
        .busy(busy), .done(done), .prescale(prescale), .modulo(modulo),
        .achieved(achieved), .compare(compare),
        .err_range(err_range), .err_invalid(err_invalid)
    );

    task automatic chk(input string req, input longint unsigned act, input longint unsigned exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Behavioural model of one request
    typedef struct {
        longint unsigned ps, md, ach, cmp;
        bit rng, inv;
    } res_t;

    function automatic res_t model(input longint unsigned p, input longint unsigned d, input bit en);
        res_t r;
        longint unsigned ps, pc, dd;
        int top;
        r = '{0, 0, 0, 0, 0, 0};
        if (p <= 64'hFFFF) ps = 0;
        else begin
            top = 0;
            for (int i = 0; i < 32; i++) if (p[i]) top = i;
            ps = longint'(top + 1 - 16);
        end
        if (ps > 7) begin r.rng = 1; return r; end
        pc = (p + ((64'd1 << ps) >> 1)) >> ps;
        if (pc == 0) begin r.inv = 1; return r; end
        r.ps  = ps;
        r.md  = pc - 1;
        r.ach = pc << ps;
        dd    = en ? d : 0;
        r.cmp = (r.md * dd + (r.ach >> 1)) / r.ach;
        return r;
    endfunction

    // Launch one request and compare the handshake on every clock
    task automatic run(input longint unsigned p, input longint unsigned d, input bit en,
                       input bit intrude, input string tag);
        res_t e;
        int lat;
        e   = model(p, d, en);
        lat = (e.rng || e.inv) ? LAT_ERR : LAT_OK;
        @(negedge clk);
        req_period = p[31:0]; req_duty = d[31:0]; req_enable = en; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R8 busy rises", busy, 1);
        chk("R8 done low at launch", done, 0);
        for (int k = 1; k <= lat; k++) begin
            if (intrude && k == 3) begin
                req_period = 32'd5; req_duty = 32'd1; req_enable = ~en; start = 1'b1;
            end
            @(negedge clk);
            start = 1'b0;
            if (busy !== 1'b1) chk({"R8 busy held ", tag}, busy, 1);
            if (done !== (k == lat)) chk({"R9 done timing ", tag}, done, (k == lat));
        end
        chk({"R9 done at latency ", tag}, done, 1);
        chk({"R1 prescale ", tag}, prescale, e.ps);
        chk({"R3 modulo ", tag}, modulo, e.md);
        chk({"R5 achieved ", tag}, achieved, e.ach);
        chk({"R7 compare ", tag}, compare, e.cmp);
        chk({"R2 err_range ", tag}, err_range, e.rng);
        chk({"R4 err_invalid ", tag}, err_invalid, e.inv);
        @(negedge clk);
        chk({"R8 idle after done ", tag}, busy, 0);
        chk({"R8 single done ", tag}, done, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R8 reset busy", busy, 0);
        chk("R8 reset done", done, 0);
        chk("R2 reset err_range", err_range, 0);
        chk("R4 reset err_invalid", err_invalid, 0);

        run(1000, 250, 1, 0, "R7 basic");
        run(64'hFFFF, 64'h8000, 1, 0, "R1 max unscaled");
        run(64'h10000, 100, 1, 0, "R1 first scaled");
        run(64'h1FFFF, 64'h1FFFF, 1, 0, "R3 round to full");
        run(64'h12345, 12345, 1, 0, "R3 odd rounding");
        run(64'h7FFFFF, 64'h400000, 1, 0, "R1 prescale 7");
        run(64'h800000, 5, 1, 0, "R2 just too long");
        run(64'hFFFFFFFF, 5, 1, 0, "R2 all ones");
        run(0, 7, 1, 0, "R4 zero period");
        run(1, 1, 1, 0, "R3 single count");
        run(5000, 2500, 0, 0, "R6 disabled");
        run(100, 300, 1, 0, "R7 duty above period");
        run(3, 2, 1, 0, "R7 tiny half");
        run(40000, 10000, 1, 1, "R10 start while busy");
        run(5, 1, 1, 0, "R10 later start taken");

        for (int i = 0; i < 40; i++) begin
            longint unsigned p, d;
            p = longint'($urandom) >> ($urandom % 32);
            d = longint'($urandom) >> ($urandom % 32);
            run(p, d, ($urandom % 4) != 0, (i % 7) == 0, "R1 R7 random");
        end

        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL R8 watchdog actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule